// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synchronous static memory with late-write timing, meant for fast cache or switch buffering. The address, write strobe, lane strobes and select are captured on the rising clock edge. For a write, the data word is taken from the shared bidirectional bus on the rising edge that follows, and it waits in a one-entry write buffer. The buffer is moved into the array on the next rising edge. For a read, the word is latched and launched onto the bus at the falling edge of the same cycle in which the read was captured.

The organisation is chosen by a parameter. The wide form has four 9-bit lanes (36 bits). The narrow form has two 9-bit lanes (18 bits). Writes can be restricted to any subset of lanes. A read that hits the address held in the write buffer returns the buffered lanes merged with the array contents for the other lanes. The bus driver is controlled by an asynchronous active-low output enable. The driver is also held off for the whole cycle in which late write data is being collected.

Top module: `lw_sram`

## Requirements
- R1: A cycle with `sel_n` low and `wr_n` low at a rising edge is a write of the captured `addr`. A later read of that address returns the written word.
- R2: The write data is the value on `dq` at the rising edge one cycle after the edge that captured the write's address. Values on `dq` at the address edge itself are not stored.
- R3: Read data is driven on `dq` after the falling edge of the cycle whose rising edge captured the read. Between that rising edge and the falling edge, a read that follows a non-read cycle leaves `dq` floating.
- R4: A rising edge with `sel_n` high performs neither a read nor a write, whatever `wr_n`, `lane_n` and `dq` hold. `dq` floats during that cycle.
- R5: `lane_n[i]` is active low and enables bits [9i+8:9i] on a write. Lanes whose bit is high keep their old contents. With all bits high, nothing changes.
- R6: `lane_n` has no effect on reads. The full word is returned whatever its value.
- R7: While `oe_n` is high, `dq` floats. A change of `oe_n` takes effect at once, without waiting for a clock edge.
- R8: From reset until the first read, `dq` floats.
- R9: A read in the cycle right after a write to the same address returns the buffered lanes of that write, merged with the previous contents of the other lanes.
- R10: Back-to-back writes to different addresses, issued on consecutive cycles, are all stored.
- R11: During the cycle in which late write data is being collected, the block does not drive `dq`, even when the preceding cycle was a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Control is captured on the rising edge; read data launches on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select, captured on the rising edge |
| wr_n | input | 1 | Active-low write strobe, captured on the rising edge |
| lane_n | input | LANES (4) | Active-low lane write enables, one per 9-bit lane |
| addr | input | ADDR_W (9) | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | DATA_W (36) | Shared data bus |

## Verification
The block's results are due at different times:
- Write data is due at the first rising edge after the address edge.
- Read data is due just after the falling edge that follows the read's rising edge, half a cycle after capture.
- The bus is released as soon as a non-read cycle is captured.
- The output enable acts at once, with no clock edge involved.

The bench sets inputs 1 ns after a rising edge and samples the bus at one of three points: 1 ns after the rising edge, 1 ns after the falling edge, or a fraction of a nanosecond after an `oe_n` change. Each check therefore lands in the half-cycle where its result is settled. A pull-up on the bench side makes a floating bus read as all ones, and the test data never uses that value.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;
  localparam int LANE_BITS = 9;
  localparam int MAX_LANES = 4;
  localparam int MAX_W     = MAX_LANES * LANE_BITS;

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} op_e;

  // Decode the registered operation from active-low select and write strobe.
  function automatic op_e decode_op(input logic sel_n, input logic wr_n);
    if (sel_n)     return OP_IDLE;
    else if (wr_n) return OP_READ;
    else           return OP_WRITE;
  endfunction

  // Take each lane from upd where take is set, from base elsewhere.
  function automatic logic [MAX_W-1:0] merge_lanes(input logic [MAX_W-1:0] base,
                                                   input logic [MAX_W-1:0] upd,
                                                   input logic [MAX_LANES-1:0] take);
    logic [MAX_W-1:0] res;
    for (int l = 0; l < MAX_LANES; l++)
      res[l*LANE_BITS +: LANE_BITS] = take[l] ? upd[l*LANE_BITS +: LANE_BITS]
                                              : base[l*LANE_BITS +: LANE_BITS];
    return res;
  endfunction
endpackage

// File: rtl/lw_ctl_capture.sv
`timescale 1ns/1ps
module lw_ctl_capture
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      op_q   <= decode_op(sel_n, wr_n);
      addr_q <= addr;
      // lane enables only matter for writes
      mask_q <= (!sel_n && !wr_n) ? ~lane_n : '0;
    end
  end
endmodule

// File: rtl/lw_write_buffer.sv
`timescale 1ns/1ps
module lw_write_buffer #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] take_addr,
  input  logic [LANES-1:0]  take_mask,
  input  logic [DATA_W-1:0] din,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LANES-1:0]  wb_mask,
  output logic [DATA_W-1:0] wb_data
);
  // One entry, live for one cycle. The array commits it on the next edge
  // while this edge may load the following write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_mask  <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= take;
      if (take) begin
        wb_addr <= take_addr;
        wb_mask <= take_mask;
        wb_data <= din;
      end
    end
  end
endmodule

// File: rtl/lw_array.sv
`timescale 1ns/1ps
module lw_array
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_BITS-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g])
        bank[wr_addr] <= wr_data[g*LANE_BITS +: LANE_BITS];
    end
    assign rd_data[g*LANE_BITS +: LANE_BITS] = bank[rd_addr];
  end
endmodule

// File: rtl/lw_read_port.sv
`timescale 1ns/1ps
module lw_read_port #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_read,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] word_in,
  output logic              bus_drive,
  inout  wire  [DATA_W-1:0] dq
);
  logic              armed_q;
  logic [DATA_W-1:0] dout_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      armed_q <= cyc_read;
      if (cyc_read) dout_q <= word_in;
    end
  end

  // Off at once when a non-read cycle is captured, and whenever oe_n is high.
  assign bus_drive = armed_q && cyc_read && !oe_n;
  assign dq = bus_drive ? dout_q : 'z;
endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter bit WIDE   = 1'b1,
  parameter int ADDR_W = 9,
  localparam int LANES  = WIDE ? 4 : 2,
  localparam int DATA_W = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  inout  wire  [DATA_W-1:0] dq
);
  op_e               op_q;
  logic [ADDR_W-1:0] cap_addr;
  logic [LANES-1:0]  cap_mask;
  logic              cyc_read, cyc_write;
  logic              wb_valid;
  logic [ADDR_W-1:0] wb_addr;
  logic [LANES-1:0]  wb_mask;
  logic [DATA_W-1:0] wb_data;
  logic [DATA_W-1:0] arr_rd;
  logic              wb_hit;
  logic [LANES-1:0]  hit_mask;
  logic [MAX_W-1:0]  merged;
  logic [DATA_W-1:0] rd_word;
  logic              bus_drive;

  lw_ctl_capture #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .lane_n(lane_n),
    .addr(addr), .op_q(op_q), .addr_q(cap_addr), .mask_q(cap_mask)
  );

  assign cyc_read  = (op_q == OP_READ);
  assign cyc_write = (op_q == OP_WRITE);

  lw_write_buffer #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .take(cyc_write), .take_addr(cap_addr),
    .take_mask(cap_mask), .din(dq), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_mask(wb_mask), .wb_data(wb_data)
  );

  lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .wr_en(wb_valid), .wr_addr(wb_addr), .wr_mask(wb_mask),
    .wr_data(wb_data), .rd_addr(cap_addr), .rd_data(arr_rd)
  );

  // Reads see the uncommitted write for its enabled lanes.
  assign wb_hit   = wb_valid && (wb_addr == cap_addr);
  assign hit_mask = wb_hit ? wb_mask : '0;
  assign merged   = merge_lanes(MAX_W'(arr_rd), MAX_W'(wb_data), MAX_LANES'(hit_mask));
  assign rd_word  = merged[DATA_W-1:0];

  lw_read_port #(.DATA_W(DATA_W)) u_rport (
    .clk(clk), .rst_n(rst_n), .cyc_read(cyc_read), .oe_n(oe_n),
    .word_in(rd_word), .bus_drive(bus_drive), .dq(dq)
  );
endmodule

// File: rtl/lw_sram_chk.sv
`timescale 1ns/1ps
module lw_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic wr_n,
  input logic oe_n,
  input logic cyc_read,
  input logic cyc_write,
  input logic wb_valid,
  input logic bus_drive
);
  // R1
  write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n) |=> cyc_write);

  // R2
  late_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_write |=> wb_valid);

  // R4
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (!cyc_read && !cyc_write));

  // R7
  oe_float_chk: assert property (@(negedge clk) disable iff (!rst_n)
    oe_n |-> !bus_drive);

  // R11
  late_write_hold_off_chk: assert property (@(negedge clk) disable iff (!rst_n)
    cyc_write |-> !bus_drive);
endmodule

bind lw_sram lw_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
  .cyc_read(cyc_read), .cyc_write(cyc_write), .wb_valid(wb_valid),
  .bus_drive(bus_drive)
);

// File: tb/lw_sram_test.sv
`timescale 1ns/1ps
module lw_sram_test;
  localparam int AW = 9;
  localparam int L  = 4;
  localparam int W  = 36;
  localparam logic [W-1:0] FLOAT = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b0;
  logic [L-1:0]  lane_n = '1;
  logic [AW-1:0] addr = '0;
  logic          tb_en = 1'b0;
  logic [W-1:0]  tb_val = '0;
  wire  [W-1:0]  dq;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [W-1:0] model [1 << AW];

  always #2 clk = ~clk;

  assign dq = tb_en ? tb_val : 'z;
  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup pu (dq[i]);
  end

  lw_sram #(.WIDE(1'b1), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .lane_n(lane_n),
    .addr(addr), .oe_n(oe_n), .dq(dq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bitwise lane merge, active-low enables
  function automatic logic [W-1:0] apply(input logic [W-1:0] old, input logic [W-1:0] nw,
                                         input logic [L-1:0] en_n);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) r[b] = en_n[b / 9] ? old[b] : nw[b];
    return r;
  endfunction

  // set controls, pass a rising edge, end 1 ns after it with bench drive off
  task automatic op(input logic s, input logic w, input logic [L-1:0] ln, input logic [AW-1:0] a);
    sel_n = s; wr_n = w; lane_n = ln; addr = a;
    @(posedge clk); #1;
    tb_en = 1'b0;
  endtask

  task automatic idle();
    op(1'b1, 1'b1, '1, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input logic [L-1:0] ln);
    op(1'b0, 1'b0, ln, a);
    tb_val = d; tb_en = 1'b1;
    model[a] = apply(model[a], d, ln);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [L-1:0] ln, input string req);
    op(1'b0, 1'b1, ln, a);
    @(negedge clk); #1;
    chk(req, dq, model[a]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R8 float after edge", dq, FLOAT);
      @(negedge clk); #1;
      chk("R8 float after falling edge", dq, FLOAT);
    end
  endtask

  task automatic t_basic();
    wr(9'h001, 36'h1_2345_6789, '0);
    wr(9'h002, 36'h0_ABCD_0123, '0);
    wr(9'h003, 36'h5_5AA5_3C3C, '0);
    idle();
    rd_chk(9'h001, '0, "R1 read A1");
    rd_chk(9'h002, '0, "R10 back-to-back A2");
    rd_chk(9'h003, '0, "R10 back-to-back A3");
  endtask

  task automatic t_read_timing();
    idle();
    op(1'b0, 1'b1, '0, 9'h001);
    chk("R3 float before falling edge", dq, FLOAT);
    @(negedge clk); #1;
    chk("R3 data after falling edge", dq, model[9'h001]);
  endtask

  task automatic t_late_data();
    idle();
    tb_val = 36'h0_DEAD_0000; tb_en = 1'b1;   // junk across the address edge
    op(1'b0, 1'b0, '0, 9'h004);
    tb_val = 36'h2_4680_1357; tb_en = 1'b1;
    model[9'h004] = 36'h2_4680_1357;
    idle();
    idle();
    rd_chk(9'h004, '0, "R2 late data stored");
  endtask

  task automatic t_lanes();
    wr(9'h005, 36'h1_1111_1111, '0);
    wr(9'h005, 36'h2_2222_2222, 4'b1010);
    idle();
    rd_chk(9'h005, '0, "R5 lanes 0,2 written");
    wr(9'h005, 36'h3_3333_3333, 4'b1111);
    idle();
    rd_chk(9'h005, '0, "R5 no lane enabled");
  endtask

  task automatic t_ignore_lanes();
    idle();
    rd_chk(9'h002, 4'b1111, "R6 read lane_n all high");
    rd_chk(9'h002, 4'b0110, "R6 read lane_n mixed");
  endtask

  task automatic t_deselect();
    op(1'b1, 1'b0, '0, 9'h001);
    chk("R4 float in deselect", dq, FLOAT);
    tb_val = 36'h0_0BAD_0BAD; tb_en = 1'b1;
    idle();
    idle();
    rd_chk(9'h001, '0, "R4 deselect no write");
  endtask

  task automatic t_oe();
    idle();
    rd_chk(9'h003, '0, "R7 baseline");
    oe_n = 1'b1; #0.2;
    chk("R7 float when oe_n high", dq, FLOAT);
    oe_n = 1'b0; #0.2;
    chk("R7 drive when oe_n low", dq, model[9'h003]);
  endtask

  task automatic t_raw();
    wr(9'h006, 36'h4_0102_0304, '0);
    idle();
    wr(9'h006, 36'h0_F0E0_D0C0, 4'b1100);
    rd_chk(9'h006, 4'b0000, "R9 read of buffered write");
    rd_chk(9'h006, '0, "R9 read after commit");
  endtask

  task automatic t_hold_off();
    idle();
    rd_chk(9'h001, '0, "R11 read before write");
    op(1'b0, 1'b0, '0, 9'h007);
    chk("R11 released in late-data cycle", dq, FLOAT);
    tb_val = 36'h6_789A_BCDE; tb_en = 1'b1;
    model[9'h007] = 36'h6_789A_BCDE;
    @(negedge clk); #1;
    chk("R11 bench value intact", dq, 36'h6_789A_BCDE);
    idle();
    rd_chk(9'h007, '0, "R11 write after read stored");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_read_timing();
    t_late_data();
    t_lanes();
    t_ignore_lanes();
    t_deselect();
    t_oe();
    t_raw();
    t_hold_off();
    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule